// File: doc/BRIEF.md
# 4x4 Dequantize, Inverse Transform and Reconstruct Engine

This block turns one 4x4 block of quantized residual coefficients back into picture samples. It rescales each coefficient with a per-position scale and weight and a block-wide left shift. It can swap the first coefficient for an externally computed DC value. It then runs a separable 4-point integer inverse transform, rows first and then columns, rounds the residual, adds it to the prediction samples and clips the sum to the 8-bit range.

All block inputs arrive in parallel and are captured on the cycle that `start` is accepted. The engine then works through a small state machine. In `S_IDLE` it waits; accepting `start` moves it to `S_ROWS`. `S_ROWS` registers the row pass and moves to `S_COLS`. `S_COLS` registers the column pass and moves to `S_EMIT`. `S_EMIT` presents one reconstructed sample per cycle in raster order and stays there until sample 15, then moves to `S_DONE`. `S_DONE` raises `done` for one cycle and returns to `S_IDLE`. A new block is accepted only from `S_IDLE`.

Top module: `iqt_recon_top`

## Requirements
- R1: After reset `busy`, `out_valid` and `done` are low and the engine sits in `S_IDLE`.
- R2: For every position i, the low 16 bits of `scale[i]*weight[i]` are read as a signed 16-bit factor and multiplied by the signed coefficient to give a 32-bit product. Position i = 4*row + column, and element i sits at bits [16*i+15:16*i] of each packed input.
- R3: The 32-bit product is shifted left by `qp_shift` and kept to 32 bits. It then gets 8 added, is arithmetically shifted right by 4 and saturated to -32768..32767.
- R4: When `intra` is 1, dequantized coefficient 0 is replaced by `dc_in`. When `intra` is 0, `dc_in` has no effect.
- R5: The 4-point pass maps d0..d3 to (a+e, b+f, b-f, a-e), where a=d0+d2, b=d0-d2, f=(d1>>>1)-d3 and e=d1+(d3>>>1). It is applied to each row of the dequantized block, then to each column of the row results.
- R6: Every add and subtract of the transform is done in 16-bit two's complement and wraps on overflow.
- R7: Each transform output v becomes (v+32)>>>6. It is added to the unsigned prediction sample at the same position and clipped to 0..255. The prediction for position i sits at bits [8*i+7:8*i] of `pred_in`.
- R8: If `start` is accepted on the cycle ending at clock edge k, the samples appear with `out_valid` high after edges k+2 through k+17, in raster order, with `out_idx` running 0..15.
- R9: `done` is high for exactly the one cycle following the last valid sample, and `busy` then drops one cycle later.
- R10: `start` is ignored while `busy` is high, and block inputs changed after the accepting cycle do not alter the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to accept a new block |
| coef_in | input | 256 | Sixteen signed quantized coefficients, raster order |
| pred_in | input | 128 | Sixteen unsigned prediction samples, raster order |
| scale_in | input | 256 | Sixteen unsigned inverse-scale entries |
| weight_in | input | 256 | Sixteen unsigned weight entries |
| qp_shift | input | 4 | Left shift applied to every dequant product |
| intra | input | 1 | Replace dequantized coefficient 0 with `dc_in` |
| dc_in | input | 16 | Signed substitute DC coefficient |
| busy | output | 1 | Engine is not in `S_IDLE` |
| out_valid | output | 1 | `out_pix` carries a reconstructed sample |
| out_idx | output | 4 | Raster position of the current sample |
| out_pix | output | 8 | Reconstructed sample |
| done | output | 1 | One-cycle pulse after the last sample |

## Verification
Counting from the clock edge that accepts `start`, nothing is valid after the first two edges. Sample n appears after edge 2+n. `done` follows after edge 18, and `busy` is low after edge 19. The bench raises `start` just after a falling edge and samples every output at the following falling edges, so each check lands mid-cycle at the exact edge offset the schedule predicts. It also scrambles the block inputs immediately after acceptance and issues a stray `start` mid-run, so any leak of late inputs shows up in the compared samples.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
    localparam int SIDE = 4;
    localparam int NUM  = SIDE * SIDE;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROWS,
        S_COLS,
        S_EMIT,
        S_DONE
    } iqt_state_e;
endpackage

// File: rtl/iqt_dequant.sv
module iqt_dequant #(
    parameter int CW = 16,
    parameter int QW = 4
) (
    input  logic [CW-1:0] coef,
    input  logic [CW-1:0] scale,
    input  logic [CW-1:0] weight,
    input  logic [QW-1:0] shift,
    output logic [CW-1:0] dq
);
    localparam int PW = 2 * CW;

    logic [PW-1:0]        sw_full;
    logic signed [CW-1:0] sw;
    logic signed [PW-1:0] prod;
    logic [PW-1:0]        shl;
    logic signed [PW:0]   rnd;
    logic signed [PW:0]   q;
    logic                 fits;

    always_comb begin
        sw_full = PW'(scale) * PW'(weight);
        sw      = sw_full[CW-1:0];
        prod    = PW'($signed(coef)) * PW'(sw);
        shl     = prod << shift;
        rnd     = $signed({shl[PW-1], shl}) + (PW+1)'(8);
        q       = rnd >>> 4;
        fits    = (q[PW:CW-1] == '0) || (q[PW:CW-1] == '1);
        if (fits)
            dq = q[CW-1:0];
        else if (q[PW])
            dq = {1'b1, {(CW-1){1'b0}}};
        else
            dq = {1'b0, {(CW-1){1'b1}}};
    end
endmodule

// File: rtl/iqt_bfly.sv
module iqt_bfly #(
    parameter int CW = 16
) (
    input  logic [4*CW-1:0] d_in,
    output logic [4*CW-1:0] y_out
);
    logic signed [CW-1:0] d0, d1, d2, d3;
    logic signed [CW-1:0] ev_s, ev_d, od_a, od_b;

    always_comb begin
        d0   = d_in[0*CW +: CW];
        d1   = d_in[1*CW +: CW];
        d2   = d_in[2*CW +: CW];
        d3   = d_in[3*CW +: CW];
        ev_s = d0 + d2;
        ev_d = d0 - d2;
        od_a = (d1 >>> 1) - d3;
        od_b = d1 + (d3 >>> 1);
        y_out[0*CW +: CW] = ev_s + od_b;
        y_out[1*CW +: CW] = ev_d + od_a;
        y_out[2*CW +: CW] = ev_d - od_a;
        y_out[3*CW +: CW] = ev_s - od_b;
    end
endmodule

// File: rtl/iqt_recon.sv
module iqt_recon #(
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic [CW-1:0] res,
    input  logic [PW-1:0] pred,
    output logic [PW-1:0] pix
);
    logic signed [CW:0]   rounded;
    logic signed [CW+1:0] sum;

    always_comb begin
        rounded = ($signed({res[CW-1], res}) + (CW+1)'(32)) >>> 6;
        sum     = (CW+2)'(rounded) + $signed({{(CW+2-PW){1'b0}}, pred});
        if (sum[CW+1])
            pix = '0;
        else if (sum > $signed((CW+2)'((1 << PW) - 1)))
            pix = '1;
        else
            pix = sum[PW-1:0];
    end
endmodule

// File: rtl/iqt_recon_top.sv
module iqt_recon_top
    import iqt_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int QW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM*CW-1:0]   coef_in,
    input  logic [NUM*PW-1:0]   pred_in,
    input  logic [NUM*CW-1:0]   scale_in,
    input  logic [NUM*CW-1:0]   weight_in,
    input  logic [QW-1:0]       qp_shift,
    input  logic                intra,
    input  logic [CW-1:0]       dc_in,
    output logic                busy,
    output logic                out_valid,
    output logic [$clog2(NUM)-1:0] out_idx,
    output logic [PW-1:0]       out_pix,
    output logic                done
);
    localparam int IW = $clog2(NUM);

    iqt_state_e state, state_nx;
    logic [IW-1:0] cnt;
    logic          accept;

    logic [CW-1:0] dq_w  [NUM];
    logic [CW-1:0] dq_q  [NUM];
    logic [CW-1:0] row_w [NUM];
    logic [CW-1:0] row_q [NUM];
    logic [CW-1:0] col_w [NUM];
    logic [CW-1:0] res_q [NUM];
    logic [PW-1:0] pred_q[NUM];
    logic [PW-1:0] pix_w [NUM];

    assign accept = (state == S_IDLE) && start;

    // dequant lanes, with optional DC swap on lane 0
    for (genvar i = 0; i < NUM; i++) begin : g_dq
        logic [CW-1:0] lane_dq;
        iqt_dequant #(.CW(CW), .QW(QW)) u_dq (
            .coef  (coef_in  [i*CW +: CW]),
            .scale (scale_in [i*CW +: CW]),
            .weight(weight_in[i*CW +: CW]),
            .shift (qp_shift),
            .dq    (lane_dq)
        );
        if (i == 0) begin : g_dc
            assign dq_w[i] = intra ? dc_in : lane_dq;
        end else begin : g_ac
            assign dq_w[i] = lane_dq;
        end
    end

    // row pass then column pass
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        logic [4*CW-1:0] y;
        iqt_bfly #(.CW(CW)) u_bf (
            .d_in ({dq_q[r*SIDE+3], dq_q[r*SIDE+2], dq_q[r*SIDE+1], dq_q[r*SIDE]}),
            .y_out(y)
        );
        for (genvar c = 0; c < SIDE; c++) begin : g_o
            assign row_w[r*SIDE+c] = y[c*CW +: CW];
        end
    end

    for (genvar c = 0; c < SIDE; c++) begin : g_col
        logic [4*CW-1:0] y;
        iqt_bfly #(.CW(CW)) u_bf (
            .d_in ({row_q[3*SIDE+c], row_q[2*SIDE+c], row_q[SIDE+c], row_q[c]}),
            .y_out(y)
        );
        for (genvar r = 0; r < SIDE; r++) begin : g_o
            assign col_w[r*SIDE+c] = y[r*CW +: CW];
        end
    end

    for (genvar i = 0; i < NUM; i++) begin : g_rc
        iqt_recon #(.CW(CW), .PW(PW)) u_rc (
            .res (res_q[i]),
            .pred(pred_q[i]),
            .pix (pix_w[i])
        );
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_ROWS;
            S_ROWS: state_nx = S_COLS;
            S_COLS: state_nx = S_EMIT;
            S_EMIT: if (cnt == IW'(NUM - 1)) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < NUM; i++) begin
                dq_q[i]   <= '0;
                row_q[i]  <= '0;
                res_q[i]  <= '0;
                pred_q[i] <= '0;
            end
        end else begin
            if (accept) begin
                for (int i = 0; i < NUM; i++) begin
                    dq_q[i]   <= dq_w[i];
                    pred_q[i] <= pred_in[i*PW +: PW];
                end
            end
            if (state == S_ROWS) row_q <= row_w;
            if (state == S_COLS) begin
                res_q <= col_w;
                cnt   <= '0;
            end
            if (state == S_EMIT) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        out_valid = (state == S_EMIT);
        out_idx   = out_valid ? cnt : '0;
        out_pix   = out_valid ? pix_w[cnt] : '0;
        done      = (state == S_DONE);
    end
endmodule

// File: rtl/iqt_recon_chk.sv
module iqt_recon_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          out_valid,
    input logic [IW-1:0] out_idx,
    input logic          done
);
    // R8: a block always starts at raster position 0
    a_r8_first_idx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_idx == '0);

    // R8: raster positions advance by one per cycle
    a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_idx == IW'($past(out_idx) + 1'b1));

    // R8: no sample in the cycle right after acceptance
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !out_valid);

    // R9: done follows the last sample
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && $past(out_idx) == '1 && !out_valid));

    // R9: done is a single-cycle pulse followed by idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: samples are only produced while busy
    a_r10_busy_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind iqt_recon_top iqt_recon_chk #(.IW($clog2(iqt_pkg::NUM))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .out_valid(out_valid),
    .out_idx  (out_idx),
    .done     (done)
);

// File: tb/iqt_recon_top_bench.sv
`timescale 1ns/1ps
module iqt_recon_top_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, start, intra;
    logic [255:0] coef_in, scale_in, weight_in;
    logic [127:0] pred_in;
    logic [3:0]   qp_shift;
    logic [15:0]  dc_in;
    logic         busy, out_valid, done;
    logic [3:0]   out_idx;
    logic [7:0]   out_pix;

    iqt_recon_top u_iqt_recon_top (
        .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in),
        .pred_in(pred_in), .scale_in(scale_in), .weight_in(weight_in),
        .qp_shift(qp_shift), .intra(intra), .dc_in(dc_in), .busy(busy),
        .out_valid(out_valid), .out_idx(out_idx), .out_pix(out_pix), .done(done)
    );

    int n_run = 0, n_fail = 0;

    logic [15:0] b_coef[16], b_scale[16], b_weight[16];
    logic [7:0]  b_pred[16];
    logic [3:0]  b_qp;
    logic        b_intra;
    logic [15:0] b_dc;
    int          exp_pix[16];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // model of R2 and R3, with R4 applied by the caller
    function automatic shortint dq_ref(input int i);
        logic [31:0] full;
        shortint     sw;
        longint      p, r;
        int          sh;
        full = 32'(b_scale[i]) * 32'(b_weight[i]);
        sw   = shortint'(full[15:0]);
        p    = longint'(shortint'(b_coef[i])) * longint'(sw);
        sh   = int'(p << b_qp);
        r    = (longint'(sh) + 8) >>> 4;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return shortint'(r);
    endfunction

    // model of R5 with R6 wrap
    function automatic void bf_ref(input shortint d0, d1, d2, d3,
                                   output shortint o0, o1, o2, o3);
        shortint a, b, f, e;
        a = d0 + d2;
        b = d0 - d2;
        f = (d1 >>> 1) - d3;
        e = d1 + (d3 >>> 1);
        o0 = a + e;
        o1 = b + f;
        o2 = b - f;
        o3 = a - e;
    endfunction

    function automatic void build_expected();
        shortint d[16], t[16], v[16];
        int      rr;
        for (int i = 0; i < 16; i++) d[i] = dq_ref(i);
        if (b_intra) d[0] = shortint'(b_dc);
        for (int r = 0; r < 4; r++)
            bf_ref(d[4*r], d[4*r+1], d[4*r+2], d[4*r+3],
                   t[4*r], t[4*r+1], t[4*r+2], t[4*r+3]);
        for (int c = 0; c < 4; c++)
            bf_ref(t[c], t[4+c], t[8+c], t[12+c], v[c], v[4+c], v[8+c], v[12+c]);
        for (int i = 0; i < 16; i++) begin
            rr = ((int'(v[i]) + 32) >>> 6) + int'(b_pred[i]);
            exp_pix[i] = (rr < 0) ? 0 : (rr > 255) ? 255 : rr;
        end
    endfunction

    task automatic drive_inputs();
        for (int i = 0; i < 16; i++) begin
            coef_in[16*i +: 16]   = b_coef[i];
            scale_in[16*i +: 16]  = b_scale[i];
            weight_in[16*i +: 16] = b_weight[i];
            pred_in[8*i +: 8]     = b_pred[i];
        end
        qp_shift = b_qp;
        intra    = b_intra;
        dc_in    = b_dc;
    endtask

    task automatic scramble();
        for (int i = 0; i < 8; i++) begin
            coef_in[32*i +: 32]   = $urandom;
            scale_in[32*i +: 32]  = $urandom;
            weight_in[32*i +: 32] = $urandom;
        end
        for (int i = 0; i < 4; i++) pred_in[32*i +: 32] = $urandom;
        qp_shift = 4'($urandom);
        intra    = ~intra;
        dc_in    = 16'($urandom);
    endtask

    // one block through the engine; poke raises a stray start mid-run (R10)
    task automatic run_block(input string req, input bit poke);
        build_expected();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);              // after accepting edge k
        start = 1'b0;
        scramble();                  // R10: late input changes must not matter
        chk(!out_valid, "R8", "valid after k", out_valid, 0);
        for (int j = 1; j <= 19; j++) begin
            @(negedge clk);
            if (poke && j == 6) start = 1'b1;
            if (poke && j == 7) start = 1'b0;
            if (j == 1) chk(!out_valid, "R8", "valid after k+1", out_valid, 0);
            else if (j <= 17) begin
                chk(out_valid === 1'b1, "R8", "valid", out_valid, 1);
                chk(out_idx == 4'(j-2), "R8", "raster index", out_idx, j-2);
                chk(int'(out_pix) == exp_pix[j-2], req, "sample", out_pix, exp_pix[j-2]);
                chk(!done, "R9", "early done", done, 0);
            end else if (j == 18) begin
                chk(done === 1'b1 && !out_valid, "R9", "done pulse", done, 1);
            end else begin
                chk(!done && !busy, "R9", "return to idle", busy, 0);
            end
        end
    endtask

    task automatic clear_block();
        for (int i = 0; i < 16; i++) begin
            b_coef[i] = '0; b_scale[i] = 16'd16; b_weight[i] = 16'd1; b_pred[i] = 8'd100;
        end
        b_qp = '0; b_intra = 1'b0; b_dc = '0;
    endtask

    task automatic t_reset();  // R1
        chk(!busy, "R1", "busy", busy, 0);
        chk(!out_valid, "R1", "valid", out_valid, 0);
        chk(!done, "R1", "done", done, 0);
    endtask

    task automatic t_dc_only();  // R2, R7: lone DC of 64 gives +1 everywhere
        clear_block();
        b_coef[0] = 16'd64;
        build_expected();
        chk(exp_pix[5] == 101, "R7", "model sanity", exp_pix[5], 101);
        run_block("R2", 1'b0);
    endtask

    task automatic t_mixed();  // R5: dense random block, rows then columns
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 16; i++) begin
                b_coef[i]   = 16'($signed(7'($urandom)));
                b_scale[i]  = 16'(10 + $urandom_range(0, 15));
                b_weight[i] = 16'(16);
                b_pred[i]   = 8'($urandom_range(40, 200));
            end
            b_qp = 4'($urandom_range(0, 5));
            b_intra = 1'b0;
            run_block("R5", 1'b0);
        end
    endtask

    task automatic t_intra();  // R4
        t_mixed_fill();
        b_coef[0] = 16'd300;
        b_intra = 1'b1; b_dc = 16'hFE0C;   // -500
        run_block("R4", 1'b0);
        b_intra = 1'b0;                    // dc_in ignored when intra is 0
        run_block("R4", 1'b0);
    endtask

    task automatic t_mixed_fill();
        for (int i = 0; i < 16; i++) begin
            b_coef[i] = 16'(i - 8); b_scale[i] = 16'd13; b_weight[i] = 16'd16;
            b_pred[i] = 8'(60 + 8*i);
        end
        b_qp = 4'd2;
    endtask

    task automatic t_signed_factor();  // R2: 200*200 low half is negative
        clear_block();
        for (int i = 0; i < 16; i++) begin
            b_scale[i] = 16'd200; b_weight[i] = 16'd200; b_pred[i] = 8'd128;
        end
        b_coef[0] = 16'd1; b_coef[6] = 16'hFFFF;
        run_block("R2", 1'b0);
    endtask

    task automatic t_saturate();  // R3: huge products clamp to 16 bits
        clear_block();
        b_scale[0] = 16'd255; b_coef[0] = 16'h7FFF;
        b_scale[3] = 16'd255; b_coef[3] = 16'h8000;
        b_qp = 4'd4;
        run_block("R3", 1'b0);
    endtask

    task automatic t_wrap();  // R6: saturated inputs overflow the butterflies
        clear_block();
        for (int i = 0; i < 16; i++) begin
            b_coef[i] = 16'h7FFF; b_scale[i] = 16'd255;
        end
        b_qp = 4'd3;
        run_block("R6", 1'b0);
    endtask

    task automatic t_clip();  // R7: both ends of the sample range
        clear_block();
        b_intra = 1'b1; b_dc = 16'd2000;
        for (int i = 0; i < 16; i++) b_pred[i] = 8'd250;
        run_block("R7", 1'b0);
        b_dc = 16'hF830;                   // -2000
        for (int i = 0; i < 16; i++) b_pred[i] = 8'd3;
        run_block("R7", 1'b0);
    endtask

    task automatic t_busy_start();  // R10
        t_mixed_fill();
        b_intra = 1'b0;
        run_block("R10", 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        clear_block(); drive_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dc_only();
        t_mixed();
        t_intra();
        t_signed_factor();
        t_saturate();
        t_wrap();
        t_clip();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule